// File: doc/BRIEF.md
# I2C Target Engine with Host Register Port

This block lets a host processor act as an I2C target (slave) on a two-wire bus. It watches the synchronized SCL and SDA lines for START and STOP conditions. It then collects a 7-bit address and the read/write bit, and compares the address with a fixed own address. On a match it acknowledges the address and tells the host through an interrupt and a status flag. The host then serves each following byte through a single data register.

Between bytes the block holds SCL low so the master waits. The host releases the clock by touching the data register in the way the current direction needs. In transmit mode it writes the next byte. In receive mode it reads the data register, and a dummy read is enough. When the block sends data, it also reports whether the master acknowledged each byte. A not-acknowledge from the master marks the end of the transfer. The pads are open-drain, so the block only has active-high "pull low" outputs for SCL and SDA.

Register map, byte-wide: control at offset 0, status at offset 1, data at offset 2. Offset 3 reads as zero.

Top module: `i2cs_target`

## Requirements
- R1: After reset, both pull-low outputs are 0, control, status and data read as 0x00, and `irq` is 0.
- R2: A falling SDA while SCL is high is a START. A rising SDA while SCL is high is a STOP. A START seen at any point, including in the middle of a byte, restarts address collection. While the enable bit (control bit 7) is 0, the block ignores the bus and pulls neither line low.
- R3: The address byte is taken MSB first: seven address bits, then the R/W bit. If its upper seven bits equal `OWN_ADDR` (default 0x3A), SDA is pulled low for the ninth clock. On a mismatch the block gives no acknowledge and raises no interrupt. It then ignores all traffic until the next START. The SDA pull-low only turns on while SCL is low.
- R4: The addressed flag (status bit 6) is set when a matching address byte completes. It is cleared by any write to the control register, and also when any later byte completes. The host therefore sees it set only at the address interrupt.
- R5: Status bit 2 holds bit 0 (the R/W bit) of the last matching address byte.
- R6: After the ninth clock of each acknowledged byte falls, the block holds SCL low. The release depends on the mode bit (control bit 4). With bit 4 set (transmit), a data-register write releases SCL. With bit 4 clear (receive), a data-register read releases it. No other register access releases SCL.
- R7: In receive mode, each data byte is shifted in MSB first. It is loaded into the data register when the eighth clock falls, and it is acknowledged by pulling SDA low during the ninth clock.
- R8: In transmit mode, the byte written to the data register is driven out MSB first, and SDA is released for the ninth clock. Status bit 0 then holds the level the master drove on that clock: 1 means not-acknowledge.
- R9: Status bit 7 (byte done) is set when the ninth clock of every acknowledged byte falls, and `irq` follows it. Writing 1 to status bit 7 clears it. If a new byte completes in the same cycle as that write, the flag stays set.
- R10: After a not-acknowledge, the host clears the mode bit and does a dummy data read. This releases SCL. The master's STOP then returns the block to idle, and the next START is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 2 | Register offset: 0 control, 1 status, 2 data |
| reg_wr | input | 1 | Register write strobe, one cycle |
| reg_rd | input | 1 | Register read strobe, one cycle (side effect on data register only) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr`, combinational |
| irq | output | 1 | Interrupt, equal to the byte-done flag |
| scl_in | input | 1 | SCL line level from the pad |
| sda_in | input | 1 | SDA line level from the pad |
| scl_pull_low | output | 1 | 1 pulls the SCL pad low |
| sda_pull_low | output | 1 | 1 pulls the SDA pad low |

## Verification
Two actions can fall in the same clock cycle: the engine setting the byte-done flag on a ninth falling clock, and the host clearing that flag by writing 1 to it. The bench provokes this by dropping SCL for the ninth clock of an address byte. It then issues the clearing status write timed to the third clock edge after the drop. That is the edge where the edge detector, behind its two-flop synchronizer, hands the falling clock to the engine. The result is judged at the interrupt pin, which must still be high because the new completion outranks the clear.

// File: rtl/i2cs_pkg.sv
`timescale 1ns/1ps
package i2cs_pkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 7;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_ADDR_ACK, ST_RX, ST_RX_ACK, ST_TX, ST_TX_ACK, ST_HOLD
  } eng_state_t;

  localparam logic [1:0] OFS_CTRL = 2'd0;
  localparam logic [1:0] OFS_STAT = 2'd1;
  localparam logic [1:0] OFS_DATA = 2'd2;

  localparam int B_EN   = 7;
  localparam int B_TXM  = 4;
  localparam int B_DONE = 7;
  localparam int B_AAS  = 6;
  localparam int B_SRW  = 2;
  localparam int B_RXAK = 0;

  function automatic logic addr_hit(input logic [BYTE_W-1:0] rx, input logic [ADDR_W-1:0] own);
    return rx[BYTE_W-1:1] == own;
  endfunction

  function automatic logic [BYTE_W-1:0] shift_in(input logic [BYTE_W-1:0] cur, input logic b);
    return {cur[BYTE_W-2:0], b};
  endfunction

  function automatic logic bus_start(input logic scl_p, scl_n, sda_p, sda_n);
    return scl_p & scl_n & sda_p & ~sda_n;
  endfunction

  function automatic logic bus_stop(input logic scl_p, scl_n, sda_p, sda_n);
    return scl_p & scl_n & ~sda_p & sda_n;
  endfunction
endpackage

// File: rtl/i2cs_sync.sv
`timescale 1ns/1ps
module i2cs_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] pipe [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) pipe[s] <= '1;
        else        pipe[s] <= d;
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) pipe[s] <= '1;
        else        pipe[s] <= pipe[s-1];
    end
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/i2cs_edges.sv
`timescale 1ns/1ps
module i2cs_edges import i2cs_pkg::*; (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_s,
  input  logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end

  assign scl_rise  = ~scl_q & scl_s;
  assign scl_fall  = scl_q & ~scl_s;
  assign start_evt = bus_start(scl_q, scl_s, sda_q, sda_s);
  assign stop_evt  = bus_stop(scl_q, scl_s, sda_q, sda_s);
endmodule

// File: rtl/i2cs_engine.sv
`timescale 1ns/1ps
module i2cs_engine import i2cs_pkg::*; #(
  parameter logic [ADDR_W-1:0] OWN_ADDR = 7'h3A
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_evt,
  input  logic              stop_evt,
  input  logic              tx_mode,
  input  logic              host_data_wr,
  input  logic              host_data_rd,
  input  logic [BYTE_W-1:0] wr_byte,
  output logic              sda_low,
  output logic              scl_low,
  output logic              byte_evt,
  output logic              addr_evt,
  output logic              rx_load,
  output logic [BYTE_W-1:0] rx_byte,
  output logic              rxak
);
  localparam int CW = $clog2(BYTE_W + 1);
  localparam logic [CW-1:0] CNT_FULL = CW'(BYTE_W);
  localparam logic [CW-1:0] CNT_LAST = CW'(BYTE_W - 1);

  eng_state_t        state;
  logic [CW-1:0]     cnt;
  logic [BYTE_W-1:0] shreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      shreg   <= '0;
      sda_low <= 1'b0;
      rxak    <= 1'b0;
    end else if (!en) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      sda_low <= 1'b0;
    end else if (start_evt) begin
      state   <= ST_ADDR;
      cnt     <= '0;
      sda_low <= 1'b0;
    end else if (stop_evt) begin
      state   <= ST_IDLE;
      sda_low <= 1'b0;
    end else begin
      unique case (state)
        ST_ADDR: begin
          if (scl_rise) begin
            shreg <= shift_in(shreg, sda_s);
            cnt   <= cnt + 1'b1;
          end else if (scl_fall && cnt == CNT_FULL) begin
            if (addr_hit(shreg, OWN_ADDR)) begin
              sda_low <= 1'b1;
              state   <= ST_ADDR_ACK;
            end else begin
              state   <= ST_IDLE;
            end
          end
        end
        ST_ADDR_ACK, ST_RX_ACK: begin
          if (scl_fall) begin
            sda_low <= 1'b0;
            state   <= ST_HOLD;
          end
        end
        ST_HOLD: begin
          if (tx_mode && host_data_wr) begin
            shreg   <= wr_byte;
            sda_low <= ~wr_byte[BYTE_W-1];
            cnt     <= '0;
            state   <= ST_TX;
          end else if (!tx_mode && host_data_rd) begin
            cnt     <= '0;
            state   <= ST_RX;
          end
        end
        ST_RX: begin
          if (scl_rise) begin
            shreg <= shift_in(shreg, sda_s);
            cnt   <= cnt + 1'b1;
          end else if (scl_fall && cnt == CNT_FULL) begin
            sda_low <= 1'b1;
            state   <= ST_RX_ACK;
          end
        end
        ST_TX: begin
          if (scl_fall) begin
            if (cnt == CNT_LAST) begin
              sda_low <= 1'b0;
              state   <= ST_TX_ACK;
            end else begin
              shreg   <= shreg << 1;
              sda_low <= ~shreg[BYTE_W-2];
              cnt     <= cnt + 1'b1;
            end
          end
        end
        ST_TX_ACK: begin
          if (scl_rise)      rxak  <= sda_s;
          else if (scl_fall) state <= ST_HOLD;
        end
        default: ;
      endcase
    end
  end

  logic ninth_state;
  assign ninth_state = (state == ST_ADDR_ACK) || (state == ST_RX_ACK) || (state == ST_TX_ACK);
  assign byte_evt = en && scl_fall && ninth_state;
  assign addr_evt = en && scl_fall && (state == ST_ADDR_ACK);
  assign rx_load  = en && scl_fall && (state == ST_RX) && (cnt == CNT_FULL);
  assign rx_byte  = shreg;
  assign scl_low  = (state == ST_HOLD);
endmodule

// File: rtl/i2cs_target.sv
`timescale 1ns/1ps
module i2cs_target import i2cs_pkg::*; #(
  parameter logic [6:0] OWN_ADDR    = 7'h3A,
  parameter int         SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] reg_addr,
  input  logic       reg_wr,
  input  logic       reg_rd,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       irq,
  input  logic       scl_in,
  input  logic       sda_in,
  output logic       scl_pull_low,
  output logic       sda_pull_low
);
  logic scl_s, sda_s;
  logic scl_rise, scl_fall, start_evt, stop_evt;
  logic byte_evt, addr_evt, rx_load, rxak;
  logic [BYTE_W-1:0] rx_byte;

  logic en_q, txm_q, done_q, aas_q, srw_q;
  logic [BYTE_W-1:0] data_q;

  logic ctrl_wr, stat_wr, data_wr, data_rd, done_w1c;
  assign ctrl_wr  = reg_wr && (reg_addr == OFS_CTRL);
  assign stat_wr  = reg_wr && (reg_addr == OFS_STAT);
  assign data_wr  = reg_wr && (reg_addr == OFS_DATA);
  assign data_rd  = reg_rd && (reg_addr == OFS_DATA);
  assign done_w1c = stat_wr && reg_wdata[B_DONE];

  i2cs_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({scl_in, sda_in}), .q({scl_s, sda_s})
  );

  i2cs_edges u_edges (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_evt(start_evt), .stop_evt(stop_evt)
  );

  i2cs_engine #(.OWN_ADDR(OWN_ADDR)) u_engine (
    .clk(clk), .rst_n(rst_n), .en(en_q), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_evt(start_evt), .stop_evt(stop_evt),
    .tx_mode(txm_q), .host_data_wr(data_wr), .host_data_rd(data_rd),
    .wr_byte(reg_wdata),
    .sda_low(sda_pull_low), .scl_low(scl_pull_low),
    .byte_evt(byte_evt), .addr_evt(addr_evt),
    .rx_load(rx_load), .rx_byte(rx_byte), .rxak(rxak)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      txm_q  <= 1'b0;
      done_q <= 1'b0;
      aas_q  <= 1'b0;
      srw_q  <= 1'b0;
      data_q <= '0;
    end else begin
      if (ctrl_wr) begin
        en_q  <= reg_wdata[B_EN];
        txm_q <= reg_wdata[B_TXM];
      end
      if (byte_evt)      done_q <= 1'b1;
      else if (done_w1c) done_q <= 1'b0;
      if (addr_evt)                 aas_q <= 1'b1;
      else if (ctrl_wr || byte_evt) aas_q <= 1'b0;
      if (addr_evt) srw_q <= rx_byte[0];
      if (rx_load)      data_q <= rx_byte;
      else if (data_wr) data_q <= reg_wdata;
    end
  end

  always_comb begin
    reg_rdata = '0;
    unique case (reg_addr)
      OFS_CTRL: begin
        reg_rdata[B_EN]  = en_q;
        reg_rdata[B_TXM] = txm_q;
      end
      OFS_STAT: begin
        reg_rdata[B_DONE] = done_q;
        reg_rdata[B_AAS]  = aas_q;
        reg_rdata[B_SRW]  = srw_q;
        reg_rdata[B_RXAK] = rxak;
      end
      OFS_DATA: reg_rdata = data_q;
      default:  reg_rdata = '0;
    endcase
  end

  assign irq = done_q;
endmodule

// File: rtl/i2cs_checker.sv
`timescale 1ns/1ps
module i2cs_checker (
  input logic clk,
  input logic rst_n,
  input logic en,
  input logic scl_s,
  input logic sda_pull_low,
  input logic scl_pull_low,
  input logic byte_evt,
  input logic done_w1c,
  input logic done,
  input logic aas,
  input logic data_acc
);
  // R2: with the block disabled, neither line is pulled low
  a_r2_off_released: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!sda_pull_low && !scl_pull_low));

  // R3: SDA pull-low only turns on while SCL is low
  a_r3_sda_on_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_pull_low) |-> !scl_s);

  // R4: addressed flag appears only together with the byte-done flag
  a_r4_aas_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(aas) |-> done);

  // R6: a stretched clock stays held until the data register is accessed
  a_r6_hold_until_access: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_pull_low && en && !data_acc) |=> scl_pull_low);

  // R9: a byte completion always leaves the done flag set
  a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    byte_evt |=> done);

  // R9: write-one-to-clear takes effect when no completion competes
  a_r9_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (done && done_w1c && !byte_evt) |=> !done);
endmodule

bind i2cs_target i2cs_checker u_i2cs_checker (
  .clk(clk), .rst_n(rst_n), .en(en_q), .scl_s(scl_s),
  .sda_pull_low(sda_pull_low), .scl_pull_low(scl_pull_low),
  .byte_evt(byte_evt), .done_w1c(done_w1c), .done(done_q), .aas(aas_q),
  .data_acc(data_wr || data_rd)
);

// File: tb/test_i2cs_target.sv
`timescale 1ns/1ps
module test_i2cs_target;
  localparam int HALF = 10;
  localparam int WDOG = 100000;
  localparam logic [6:0] OWN = 7'h3A;
  localparam logic [1:0] A_CTRL = 2'd0, A_STAT = 2'd1, A_DATA = 2'd2;

  // vector: [16] R/W (1 = master reads), [15:9] address, [8:1] data, [0] ack expected
  localparam int NVEC = 7;
  localparam logic [16:0] VEC [NVEC] = '{
    {1'b0, 7'h3A, 8'hA5, 1'b1},
    {1'b1, 7'h3A, 8'h3C, 1'b1},
    {1'b0, 7'h11, 8'h77, 1'b0},
    {1'b0, 7'h3A, 8'h00, 1'b1},
    {1'b1, 7'h3A, 8'hFF, 1'b1},
    {1'b0, 7'h3B, 8'h81, 1'b0},
    {1'b1, 7'h3A, 8'h5A, 1'b1}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] reg_addr = '0;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0] reg_wdata = '0, reg_rdata;
  logic irq, scl_drv, sda_drv;
  logic scl_m = 1'b0, sda_m = 1'b0;
  wire scl_line = ~(scl_m | scl_drv);
  wire sda_line = ~(sda_m | sda_drv);
  int n_chk = 0, n_bad = 0;

  always #5 clk = ~clk;

  i2cs_target i_i2cs_target (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
    .scl_in(scl_line), .sda_in(sda_line),
    .scl_pull_low(scl_drv), .sda_pull_low(sda_drv)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [1:0] a, output logic [7:0] d);
    reg_addr = a; reg_rd = 1'b1;
    #1 d = reg_rdata;
    @(negedge clk); reg_rd = 1'b0;
  endtask

  task automatic scl_up();
    scl_m = 1'b0;
    do @(negedge clk); while (!scl_line);
    tick(HALF);
  endtask

  task automatic scl_dn();
    scl_m = 1'b1; tick(HALF);
  endtask

  task automatic m_start();
    sda_m = 1'b0; tick(2); scl_up(); sda_m = 1'b1; tick(HALF); scl_dn();
  endtask

  task automatic m_stop();
    sda_m = 1'b1; tick(2); scl_up(); sda_m = 1'b0; tick(HALF);
  endtask

  task automatic put_bit(input logic b);
    sda_m = ~b; tick(2); scl_up(); scl_dn();
  endtask

  task automatic get_bit(output logic b);
    sda_m = 1'b0; scl_up(); b = sda_line; scl_dn();
  endtask

  // sends a byte; collide = time a done-clear write onto the ninth falling edge
  task automatic put_byte(input logic [7:0] d, input logic collide, output logic ack);
    for (int i = 7; i >= 0; i--) put_bit(d[i]);
    sda_m = 1'b0; scl_up(); ack = ~sda_line;
    scl_m = 1'b1;
    if (collide) begin
      @(posedge clk); @(posedge clk); @(negedge clk);
      reg_addr = A_STAT; reg_wdata = 8'h80; reg_wr = 1'b1;
      @(negedge clk); reg_wr = 1'b0;
    end
    tick(HALF);
  endtask

  task automatic get_byte(input logic nack, output logic [7:0] d);
    for (int i = 7; i >= 0; i--) get_bit(d[i]);
    put_bit(nack);
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (WDOG) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    summary();
  end

  initial begin
    logic [7:0] s, d;
    logic ack;
    tick(4); rst_n = 1'b1; tick(4);
    // R1 reset state
    check("R1 irq", {7'b0, irq}, 8'h00);
    check("R1 scl pull", {7'b0, scl_drv}, 8'h00);
    check("R1 sda pull", {7'b0, sda_drv}, 8'h00);
    rd_reg(A_CTRL, s); check("R1 control", s, 8'h00);
    rd_reg(A_STAT, s); check("R1 status", s, 8'h00);
    rd_reg(A_DATA, s); check("R1 data", s, 8'h00);

    // R2 disabled block ignores a matching address
    m_start(); put_byte({OWN, 1'b0}, 1'b0, ack);
    check("R2 disabled no ack", {7'b0, ack}, 8'h00);
    check("R2 disabled no irq", {7'b0, irq}, 8'h00);
    m_stop();
    wr_reg(A_CTRL, 8'h80);

    for (int v = 0; v < NVEC; v++) begin
      logic rw; logic [6:0] a; logic [7:0] dat; logic eack;
      {rw, a, dat, eack} = VEC[v];
      m_start();
      put_byte({a, rw}, 1'b0, ack);
      check("R3 address ack", {7'b0, ack}, {7'b0, eack});
      if (!eack) begin
        check("R3 mismatch no irq", {7'b0, irq}, 8'h00);
        put_byte(dat, 1'b0, ack);
        check("R3 ignored after mismatch", {6'b0, ack, sda_drv}, 8'h00);
        check("R3 no stretch after mismatch", {7'b0, scl_drv}, 8'h00);
        m_stop();
        continue;
      end
      rd_reg(A_STAT, s);
      check("R4 aas on address irq", {7'b0, s[6]}, 8'h01);
      check("R5 srw bit", {7'b0, s[2]}, {7'b0, rw});
      check("R9 irq on address", {7'b0, irq}, 8'h01);
      tick(20);
      check("R6 scl held after address", {7'b0, scl_drv}, 8'h01);
      wr_reg(A_CTRL, rw ? 8'h90 : 8'h80);
      rd_reg(A_STAT, s);
      check("R4 control write clears aas", {7'b0, s[6]}, 8'h00);
      check("R6 control write keeps hold", {7'b0, scl_drv}, 8'h01);
      wr_reg(A_STAT, 8'h80);
      check("R9 w1c clears irq", {7'b0, irq}, 8'h00);
      if (!rw) begin
        rd_reg(A_DATA, s); tick(3);
        check("R6 dummy read releases", {7'b0, scl_drv}, 8'h00);
        put_byte(dat, 1'b0, ack);
        check("R7 data ack", {7'b0, ack}, 8'h01);
        tick(20);
        check("R6 scl held after data", {7'b0, scl_drv}, 8'h01);
        rd_reg(A_STAT, s);
        check("R4 aas clear on data irq", {s[7], s[6]}, 8'h02);
        wr_reg(A_STAT, 8'h80);
        rd_reg(A_DATA, s);
        check("R7 received byte", s, dat);
      end else begin
        wr_reg(A_DATA, dat);
        get_byte(1'b1, d);
        check("R8 transmitted byte", d, dat);
        tick(20);
        rd_reg(A_STAT, s);
        check("R8 rxak nack", {s[7], s[0]}, 8'h03);
        check("R8 sda released", {7'b0, sda_drv}, 8'h00);
        check("R10 held after nack", {7'b0, scl_drv}, 8'h01);
        wr_reg(A_CTRL, 8'h80); wr_reg(A_STAT, 8'h80);
        rd_reg(A_DATA, s); tick(3);
        check("R10 dummy read releases", {7'b0, scl_drv}, 8'h00);
      end
      m_stop();
    end

    // R8 acked byte then nacked byte
    m_start(); put_byte({OWN, 1'b1}, 1'b0, ack);
    wr_reg(A_CTRL, 8'h90); wr_reg(A_STAT, 8'h80); wr_reg(A_DATA, 8'h96);
    get_byte(1'b0, d);
    check("R8 first byte", d, 8'h96);
    tick(10); rd_reg(A_STAT, s);
    check("R8 rxak ack", {s[7], s[0]}, 8'h02);
    wr_reg(A_STAT, 8'h80); wr_reg(A_DATA, 8'h2B);
    get_byte(1'b1, d);
    check("R8 second byte", d, 8'h2B);
    tick(10); rd_reg(A_STAT, s);
    check("R8 rxak after nack", {7'b0, s[0]}, 8'h01);
    wr_reg(A_CTRL, 8'h80); wr_reg(A_STAT, 8'h80); rd_reg(A_DATA, s);
    m_stop();

    // R2 START in mid-byte restarts address collection
    m_start();
    put_bit(1'b1); put_bit(1'b0); put_bit(1'b1); put_bit(1'b0);
    m_start();
    put_byte({OWN, 1'b0}, 1'b0, ack);
    check("R2 restart mid-byte ack", {7'b0, ack}, 8'h01);
    rd_reg(A_STAT, s);
    check("R2 restart flags", {s[6], s[2]}, 8'h02);
    wr_reg(A_CTRL, 8'h80); wr_reg(A_STAT, 8'h80); rd_reg(A_DATA, s);
    m_stop();

    // R9 completion and clear in one cycle: set wins
    m_start();
    put_byte({OWN, 1'b0}, 1'b1, ack);
    check("R9 set beats clear", {7'b0, irq}, 8'h01);
    wr_reg(A_STAT, 8'h80);
    check("R9 later clear", {7'b0, irq}, 8'h00);
    wr_reg(A_CTRL, 8'h80); rd_reg(A_DATA, s);
    m_stop();
    tick(10);
    check("R10 idle after stop", {6'b0, scl_drv, sda_drv}, 8'h00);
    summary();
  end
endmodule